// File: doc/BRIEF.md
# Page-Mode Parallel ROM Read Controller

This block is a synchronous read engine for an asynchronous parallel ROM that supports page reads. A host hands it a start address, a mode flag selecting 16-bit word reads or 8-bit byte reads, and an item count. The controller drives the ROM address, active-low chip and output enables, and the width-select pin. It waits a number of clock cycles derived from the clock period before capturing the data bus. It then returns each item with a one-cycle valid strobe.

The address advances by one item per read. While only the low in-page bits change, the controller uses the short page access delay. When the increment carries into the page number, or at the start of a burst, it waits the full random access delay. In byte mode the most significant data pin becomes the lowest address bit, so the controller drives that pin. The upper data lines are then ignored. Between bursts the ROM is put in standby, and a short release gap separates one burst from the next.

Top module: `prom_page_reader`

## Requirements
- R1: After reset, busy and rd_valid are 0, rom_ce_n and rom_oe_n are 1, rom_byte_n is 1 and rom_d15_oe is 0.
- R2: A request is taken only while busy is 0 and req_len is nonzero. busy reads 1 from the cycle after acceptance. A request raised while busy, or with req_len of 0, changes nothing.
- R3: The first item of a burst is captured W_RAND clock edges after acceptance, with address, chip enable and output enable unchanged over that window. W_RAND = max(ceil(70/P), ceil(25/P)), where P is the clock period in ns; this is 9 at 8 ns.
- R4: An item whose page number matches the previous item's is captured W_PAGE = ceil(25/P) edges after the previous capture; this is 4 at 8 ns.
- R5: Word mode (req_byte=0): rom_addr = cursor[20:0], rom_byte_n=1, rom_d15_oe=0, and rd_data is the full 16-bit bus.
- R6: Byte mode (req_byte=1): rom_addr = cursor[21:1], rom_d15_out = cursor[0], rom_d15_oe=1 and rom_byte_n=0. rd_data is {8'h00, rom_dq[7:0]}, so bus bits 15:8 have no effect.
- R7: A burst of N items produces exactly N one-cycle rd_valid pulses, at addresses start, start+1, and so on, in that order.
- R8: The in-page field is cursor[2:0] in word mode and cursor[3:0] in byte mode. A step that carries out of this field waits the full W_RAND edges.
- R9: On the capture of the last item, rom_ce_n and rom_oe_n go high together. busy then stays high for W_TURN = ceil(20/P) more edges (3 at 8 ns). The ROM sees at least 20 ns of chip enable high between bursts.
- R10: Whenever busy is 0, rom_ce_n and rom_oe_n are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W+1 | Start address in items (word or byte units) |
| req_byte | input | 1 | 1 selects byte mode, 0 word mode |
| req_len | input | LEN_W | Item count of the burst |
| busy | output | 1 | Burst or release gap in progress |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| rd_data | output | DATA_W | Captured item |
| rom_addr | output | ADDR_W | ROM address lines |
| rom_ce_n | output | 1 | Chip enable, active low |
| rom_oe_n | output | 1 | Output enable, active low |
| rom_byte_n | output | 1 | Width select, 1 = 16-bit, 0 = 8-bit |
| rom_d15_out | output | 1 | Lowest byte-address bit driven on the top data pin |
| rom_d15_oe | output | 1 | Drive enable for the top data pin |
| rom_dq | input | DATA_W | ROM data bus |

## Verification
A wrong wait count shows up on the very item it affects. The bench's ROM model gives corrupted data for any capture made before its delays have elapsed, so the captured word is wrong. The spacing between valid pulses also differs from the expected page or random gap. A wrong cursor or mode register shows as a wrong address pin value in the cycle after acceptance, or as a wrong data item on the next strobe. A wrong control state shows as an extra, missing or misplaced valid pulse, or as busy falling on the wrong cycle within a few edges of the last item.

// File: rtl/prom_rd_pkg.sv
`timescale 1ns/100ps
package prom_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_TURN   = 2'd2
    } rd_state_e;

    typedef enum logic [1:0] {
        WS_RAND = 2'd0,
        WS_PAGE = 2'd1,
        WS_TURN = 2'd2
    } wait_sel_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
    } rom_en_t;

    function automatic int unsigned cycles_for(int unsigned t_ns, int unsigned period_ns);
        int unsigned c;
        c = (t_ns + period_ns - 1) / period_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/prom_rd_wait.sv
`timescale 1ns/100ps
module prom_rd_wait
    import prom_rd_pkg::*;
#(
    parameter int unsigned W_RAND = 9,
    parameter int unsigned W_PAGE = 4,
    parameter int unsigned W_TURN = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  wait_sel_e sel,
    output logic      done
);
    localparam int unsigned MAXW  = max2(max2(W_RAND, W_PAGE), W_TURN);
    localparam int unsigned CNT_W = $clog2(MAXW + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        case (sel)
            WS_RAND: load_val = CNT_W'(W_RAND);
            WS_PAGE: load_val = CNT_W'(W_PAGE);
            default: load_val = CNT_W'(W_TURN);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == CNT_W'(1));

endmodule

// File: rtl/prom_rd_addr.sv
`timescale 1ns/100ps
module prom_rd_addr #(
    parameter int unsigned ADDR_W    = 21,
    parameter int unsigned PAGE_BITS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W:0]   load_addr,
    input  logic              load_byte,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              a_m1,
    output logic              byte_mode,
    output logic              page_last
);
    logic [ADDR_W:0] cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur       <= '0;
            byte_mode <= 1'b0;
        end else if (load) begin
            cur       <= load_addr;
            byte_mode <= load_byte;
        end else if (step) begin
            cur <= cur + 1'b1;
        end
    end

    always_comb begin
        if (byte_mode) begin
            rom_addr  = cur[ADDR_W:1];
            a_m1      = cur[0];
            page_last = &cur[PAGE_BITS:0];
        end else begin
            rom_addr  = cur[ADDR_W-1:0];
            a_m1      = 1'b0;
            page_last = &cur[PAGE_BITS-1:0];
        end
    end

    // R8: a step that stays inside the page leaves the page number alone
    assert_in_page_R8: assert property (@(posedge clk) disable iff (rst)
        (step && !load && !page_last) |=> $stable(rom_addr[ADDR_W-1:PAGE_BITS]));

endmodule

// File: rtl/prom_rd_fsm.sv
`timescale 1ns/100ps
module prom_rd_fsm
    import prom_rd_pkg::*;
#(
    parameter int unsigned LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [LEN_W-1:0] req_len,
    input  logic             wait_done,
    input  logic             page_last,
    output rd_state_e        state,
    output logic             accept,
    output logic             sample,
    output logic             step,
    output logic             wait_load,
    output wait_sel_e        wait_sel,
    output rom_en_t          en
);
    logic [LEN_W-1:0] remain;
    logic             last;

    always_comb begin
        accept    = (state == ST_IDLE) && req_valid && (req_len != '0);
        sample    = (state == ST_ACCESS) && wait_done;
        last      = sample && (remain == LEN_W'(1));
        step      = sample && !last;
        wait_load = accept || sample;
        if (accept || (sample && !last && page_last)) begin
            wait_sel = WS_RAND;
        end else if (last) begin
            wait_sel = WS_TURN;
        end else begin
            wait_sel = WS_PAGE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            remain <= '0;
            en     <= '{ce_n: 1'b1, oe_n: 1'b1};
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state  <= ST_ACCESS;
                        remain <= req_len;
                        en     <= '{ce_n: 1'b0, oe_n: 1'b0};
                    end
                end
                ST_ACCESS: begin
                    if (sample) begin
                        remain <= remain - 1'b1;
                        if (last) begin
                            state <= ST_TURN;
                            en    <= '{ce_n: 1'b1, oe_n: 1'b1};
                        end
                    end
                end
                ST_TURN: begin
                    if (wait_done) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10: idle means standby with outputs disabled
    assert_standby_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (en.ce_n && en.oe_n));

    // R9: chip enable is released together with output enable, entering the gap
    assert_release_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(en.ce_n) |-> (en.oe_n && state == ST_TURN));

endmodule

// File: rtl/prom_page_reader.sv
`timescale 1ns/100ps
module prom_page_reader
    import prom_rd_pkg::*;
#(
    parameter int unsigned ADDR_W        = 21,
    parameter int unsigned DATA_W        = 16,
    parameter int unsigned LEN_W         = 8,
    parameter int unsigned PAGE_BITS     = 3,
    parameter int unsigned CLK_PERIOD_NS = 8,
    parameter int unsigned T_RANDOM_NS   = 70,
    parameter int unsigned T_PAGE_NS     = 25,
    parameter int unsigned T_OE_NS       = 25,
    parameter int unsigned T_TURN_NS     = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W:0]   req_addr,
    input  logic              req_byte,
    input  logic [LEN_W-1:0]  req_len,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_ce_n,
    output logic              rom_oe_n,
    output logic              rom_byte_n,
    output logic              rom_d15_out,
    output logic              rom_d15_oe,
    input  logic [DATA_W-1:0] rom_dq
);
    localparam int unsigned W_RAND = max2(cycles_for(T_RANDOM_NS, CLK_PERIOD_NS),
                                          cycles_for(T_OE_NS, CLK_PERIOD_NS));
    localparam int unsigned W_PAGE = cycles_for(T_PAGE_NS, CLK_PERIOD_NS);
    localparam int unsigned W_TURN = cycles_for(T_TURN_NS, CLK_PERIOD_NS);
    localparam int unsigned HALF_W = DATA_W / 2;

    rd_state_e state;
    wait_sel_e wait_sel;
    rom_en_t   en;
    logic      accept, sample, step, wait_load, wait_done;
    logic      page_last, byte_mode, a_m1;

    prom_rd_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_len   (req_len),
        .wait_done (wait_done),
        .page_last (page_last),
        .state     (state),
        .accept    (accept),
        .sample    (sample),
        .step      (step),
        .wait_load (wait_load),
        .wait_sel  (wait_sel),
        .en        (en)
    );

    prom_rd_wait #(.W_RAND(W_RAND), .W_PAGE(W_PAGE), .W_TURN(W_TURN)) u_wait (
        .clk  (clk),
        .rst  (rst),
        .load (wait_load),
        .sel  (wait_sel),
        .done (wait_done)
    );

    prom_rd_addr #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .step      (step),
        .load_addr (req_addr),
        .load_byte (req_byte),
        .rom_addr  (rom_addr),
        .a_m1      (a_m1),
        .byte_mode (byte_mode),
        .page_last (page_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= sample;
            if (sample) begin
                rd_data <= byte_mode ? {{(DATA_W-HALF_W){1'b0}}, rom_dq[HALF_W-1:0]}
                                     : rom_dq;
            end
        end
    end

    assign busy        = (state != ST_IDLE);
    assign rom_ce_n    = en.ce_n;
    assign rom_oe_n    = en.oe_n;
    assign rom_byte_n  = ~byte_mode;
    assign rom_d15_oe  = byte_mode;
    assign rom_d15_out = a_m1;

    // R3: address pins hold still while an access is waiting
    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACCESS && !sample) |=> ($stable(rom_addr) && $stable(rom_d15_out)));

    // R7: results only appear inside a burst
    assert_valid_in_burst_R7: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> busy);

    // R2: a request arriving while busy leaves the mode untouched
    assert_busy_ignore_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && req_valid) |=> $stable(rom_byte_n));

endmodule

// File: tb/prom_page_reader_test.sv
`timescale 1ns/100ps
module prom_page_reader_test;
    localparam int AW = 21;
    localparam int DW = 16;
    localparam int LW = 8;
    localparam int P  = 8;
    localparam int W_RAND = (70 + P - 1) / P;
    localparam int W_PAGE = (25 + P - 1) / P;
    localparam int W_TURN = (20 + P - 1) / P;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic          req_valid;
    logic [AW:0]   req_addr;
    logic          req_byte;
    logic [LW-1:0] req_len;
    logic          busy, rd_valid;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] rom_addr;
    logic          rom_ce_n, rom_oe_n, rom_byte_n, rom_d15_out, rom_d15_oe;
    logic [DW-1:0] rom_dq;

    prom_page_reader uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_byte(req_byte), .req_len(req_len), .busy(busy), .rd_valid(rd_valid),
        .rd_data(rd_data), .rom_addr(rom_addr), .rom_ce_n(rom_ce_n),
        .rom_oe_n(rom_oe_n), .rom_byte_n(rom_byte_n), .rom_d15_out(rom_d15_out),
        .rom_d15_oe(rom_d15_oe), .rom_dq(rom_dq)
    );

    int total = 0;
    int bad   = 0;

    task automatic check(input bit ok, input string req, input longint unsigned act,
                         input longint unsigned exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ROM contents as a function of the word address
    function automatic logic [15:0] word_of(input logic [AW-1:0] a);
        return a[15:0] ^ {a[4:0], a[20:10]} ^ 16'h5A3C;
    endfunction

    function automatic logic [7:0] byte_of(input logic [AW:0] b);
        logic [15:0] w;
        w = word_of(b[AW:1]);
        return b[0] ? w[15:8] : w[7:0];
    endfunction

    // Behavioural ROM: corrupted data until every delay has elapsed
    realtime t_upper = 0, t_any = 0, t_ce = 0, t_oe = 0, t_ce_rise = -100;
    always @(rom_addr[AW-1:3] or rom_byte_n) t_upper = $realtime;
    always @(rom_addr or rom_d15_out) t_any = $realtime;
    always @(negedge rom_oe_n) t_oe = $realtime;
    always @(posedge rom_ce_n) t_ce_rise = $realtime;
    always @(negedge rom_ce_n) begin
        t_ce = $realtime;
        check(($realtime - t_ce_rise) >= 20.0, "R9 ce gap",
              longint'($realtime - t_ce_rise), 20);
    end

    task automatic model_eval();
        realtime now;
        logic ready;
        logic [15:0] w, val;
        now = $realtime;
        ready = !rom_ce_n && !rom_oe_n && (now - t_upper >= 70.0) && (now - t_ce >= 70.0)
                && (now - t_any >= 25.0) && (now - t_oe >= 25.0);
        w = word_of(rom_addr);
        if (rom_byte_n) val = w;
        else val = {rom_d15_out, 7'h55, (rom_d15_out ? w[15:8] : w[7:0])};
        if (rom_ce_n || rom_oe_n) rom_dq = 16'hFFFF;
        else if (ready) rom_dq = val;
        else rom_dq = ~val;
    endtask

    initial begin
        rom_dq = 16'hFFFF;
        #0.5;
        forever begin
            model_eval();
            #1;
        end
    end

    // Scoreboard
    logic [15:0] q_data[$];
    int          q_gap[$];
    string       q_gtag[$];
    bit          q_byte[$];
    bit          q_last[$];

    int  cnt = 0;
    bit  prev_busy = 1'b0;
    bit  tracking = 1'b0;
    int  tcnt = 0;

    always @(negedge clk) begin
        if (rst) begin
            cnt = 0;
            prev_busy = 1'b0;
        end else begin
            if (!prev_busy && busy) cnt = 0;
            else cnt++;
            prev_busy = busy;
            if (tracking) begin
                tcnt++;
                if (!busy) begin
                    check(tcnt == W_TURN, "R9 release gap", tcnt, W_TURN);
                    tracking = 1'b0;
                end
            end
            if (rd_valid) begin
                if (q_data.size() == 0) begin
                    check(1'b0, "R7 unexpected item", rd_data, 0);
                end else begin
                    logic [15:0] ed;
                    int eg;
                    string gt;
                    bit eb, el;
                    ed = q_data.pop_front();
                    eg = q_gap.pop_front();
                    gt = q_gtag.pop_front();
                    eb = q_byte.pop_front();
                    el = q_last.pop_front();
                    check(rd_data == ed, eb ? "R6 data" : "R5 data", rd_data, ed);
                    check(cnt == eg, gt, cnt, eg);
                    if (el) begin
                        check(rom_ce_n && rom_oe_n, "R9 enables released", {rom_ce_n, rom_oe_n}, 2'b11);
                        tracking = 1'b1;
                        tcnt = 0;
                    end
                end
                cnt = 0;
            end
        end
    end

    task automatic launch(input logic [AW:0] addr, input bit bmode, input int len);
        logic [AW:0] cur;
        bit wrap;
        cur = addr;
        wrap = 1'b0;
        for (int i = 0; i < len; i++) begin
            q_gap.push_back((i == 0 || wrap) ? W_RAND : W_PAGE);
            q_gtag.push_back(i == 0 ? "R3 first gap" : (wrap ? "R8 carry gap" : "R4 page gap"));
            q_byte.push_back(bmode);
            q_last.push_back(i == len - 1);
            q_data.push_back(bmode ? {8'h00, byte_of(cur)} : word_of(cur[AW-1:0]));
            wrap = bmode ? (cur[3:0] == 4'hF) : (cur[2:0] == 3'h7);
            cur = cur + 1'b1;
        end
        while (busy) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = addr;
        req_byte  = bmode;
        req_len   = LW'(len);
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R2 accepted", busy, 1);
        if (bmode) begin
            check(rom_addr == addr[AW:1], "R6 addr", rom_addr, addr[AW:1]);
            check(rom_d15_out == addr[0], "R6 a_m1", rom_d15_out, addr[0]);
            check({rom_byte_n, rom_d15_oe} == 2'b01, "R6 pins", {rom_byte_n, rom_d15_oe}, 2'b01);
        end else begin
            check(rom_addr == addr[AW-1:0], "R5 addr", rom_addr, addr[AW-1:0]);
            check({rom_byte_n, rom_d15_oe} == 2'b10, "R5 pins", {rom_byte_n, rom_d15_oe}, 2'b10);
        end
    endtask

    task automatic finish_burst();
        while (busy || q_data.size() != 0) @(negedge clk);
        check(rom_ce_n && rom_oe_n, "R10 standby", {rom_ce_n, rom_oe_n}, 2'b11);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R7 actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        req_valid = 1'b0;
        req_addr  = '0;
        req_byte  = 1'b0;
        req_len   = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check({busy, rd_valid} == 2'b00, "R1 busy/valid", {busy, rd_valid}, 0);
        check({rom_ce_n, rom_oe_n, rom_byte_n, rom_d15_oe} == 4'b1110, "R1 pins",
              {rom_ce_n, rom_oe_n, rom_byte_n, rom_d15_oe}, 4'b1110);

        // word burst crossing a page boundary (R5, R8)
        launch(22'h000005, 1'b0, 6);
        finish_burst();
        // byte burst crossing a page boundary (R6, R8)
        launch(22'h00001D, 1'b1, 6);
        finish_burst();
        // word burst at the top of the space
        launch(22'h1FFFFF, 1'b0, 2);
        finish_burst();
        // full byte page, all in-page steps (R4)
        launch(22'h3FFFF0, 1'b1, 16);
        finish_burst();
        // back-to-back bursts with a mode change (R9 gap)
        launch(22'h000123, 1'b0, 3);
        launch(22'h000456, 1'b1, 2);
        finish_burst();

        // request while busy is ignored (R2)
        launch(22'h000100, 1'b0, 20);
        repeat (5) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 22'h0003FF;
        req_byte  = 1'b1;
        req_len   = 8'd3;
        repeat (2) @(negedge clk);
        req_valid = 1'b0;
        check(rom_byte_n == 1'b1, "R2 busy request ignored", rom_byte_n, 1);
        finish_burst();

        // zero-length request is ignored (R2)
        req_valid = 1'b1;
        req_addr  = 22'h000040;
        req_byte  = 1'b0;
        req_len   = '0;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b0, "R2 zero length", busy, 0);
        @(negedge clk);
        check(rom_ce_n == 1'b1, "R10 zero length standby", rom_ce_n, 1);
        repeat (12) @(negedge clk);

        check(q_data.size() == 0, "R7 all items returned", q_data.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule